// File: doc/BRIEF.md
# Byte-Stuffing Packet Framer

This block turns a byte-wide AXI4-Stream packet into a frame for a serial link. Every frame opens with a start marker (0x7E) and closes with an end marker (0x7F). A payload byte that could be mistaken for framing is sent as an escape pair: the escape code (0x7D) first, then the byte XOR 0x20. The receiver can therefore find frame edges by looking for the two marker values alone. A CRC stage would sit upstream of this block, and a UART downstream.

An input byte can produce one or two output beats, and each packet adds two marker beats. The block runs this expansion by holding the input byte in place while it emits the extra beat. The upstream source must keep its TVALID, TDATA and TLAST steady until the handshake, as the stream protocol already requires. The output beat lives in a single register. That register advances whenever it is empty or the sink accepts it, so a link that never stalls receives one beat per clock with no idle cycles between packets.

Top module: `frame_stuffer`

## Requirements
- R1: While reset is held low, and after it, until the first input beat is presented, `m_axis_tvalid` and `s_axis_tready` are 0.
- R2: The first output beat of every packet is the start marker 0x7E. It is sent before the packet's first payload byte, including after a previous packet's end marker.
- R3: A payload byte equal to 0x7E, 0x7F or 0x7D is sent as two beats: 0x7D, then the byte XOR 0x20.
- R4: Any other payload byte is sent unchanged as one beat, in input order.
- R5: After the payload byte that carries input TLAST, the end marker 0x7F is sent. Output TLAST is 1 on that beat and 0 on every other beat.
- R6: `s_axis_tready` is 0 in any cycle where the beat being loaded is a start marker, an escape prefix or an end marker. Each payload byte is accepted exactly once, and an accepted byte is always followed by a non-code beat.
- R7: While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, the output beat (valid, data, last) holds unchanged.
- R8: With the sink always ready and input always valid, the output carries a beat every cycle with no gap within or between packets.
- R9: A single-byte packet yields start marker, the byte (escaped per R3 if it is a code), end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axis_tdata | input | DATA_W | Payload byte in |
| s_axis_tvalid | input | 1 | Payload byte valid |
| s_axis_tlast | input | 1 | Marks the last payload byte of a packet |
| s_axis_tready | output | 1 | Block accepts the payload byte this cycle |
| m_axis_tdata | output | DATA_W | Framed byte out |
| m_axis_tvalid | output | 1 | Framed byte valid |
| m_axis_tlast | output | 1 | High on the end marker beat only |
| m_axis_tready | input | 1 | Sink accepts the framed byte |

## Verification
Each output beat is loaded one rising edge after the cycle in which the output slot is free, so its value shows up on the ports just after that edge. `s_axis_tready` is combinational in the same cycle from the state, the input byte and `m_axis_tready`. The bench drives inputs on the falling edge and samples all ports 1 ns later. At that point the ready signals and the registered beat are settled. It then books the transfers that the next rising edge will complete. Output beats are compared in order against a queue that bench functions compute from the payload. Stall stability (R7) is checked by comparing each held beat with its value one cycle earlier. The no-gap property (R8) is checked by requiring valid in every sampled cycle between the first and last beat of a run in which the sink is always ready.

// File: rtl/fstuff_pkg.sv
// Package: shared types for the byte-stuffing framer.
// Assumes nothing beyond a synthesizable enum encoding.
package fstuff_pkg;
    // Sequencer phase: which kind of beat the next free output slot takes.
    typedef enum logic [1:0] {
        PH_OPEN  = 2'd0,  // no packet open; next beat is the start marker
        PH_BODY  = 2'd1,  // inside a packet; next beat is payload or escape prefix
        PH_TAIL  = 2'd2,  // escape prefix sent; next beat is the flipped byte
        PH_CLOSE = 2'd3   // last payload sent; next beat is the end marker
    } fs_phase_e;
endpackage

// File: rtl/fstuff_classify.sv
// Module: fstuff_classify
// Purpose: decides whether a payload byte collides with one of the framing
// codes, and gives the flipped form sent after an escape prefix.
// Assumes: the three codes are distinct, and none of them XOR FLIP_MASK is a code.
module fstuff_classify #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SOP_CODE  = 8'h7E,
    parameter logic [DATA_W-1:0] EOP_CODE  = 8'h7F,
    parameter logic [DATA_W-1:0] ESC_CODE  = 8'h7D,
    parameter logic [DATA_W-1:0] FLIP_MASK = 8'h20
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              needs_esc,
    output logic [DATA_W-1:0] flipped
);
    localparam int N_CODES = 3;
    localparam logic [N_CODES*DATA_W-1:0] CODE_LIST = {ESC_CODE, EOP_CODE, SOP_CODE};

    logic [N_CODES-1:0] hit;

    // One comparator per reserved code.
    generate
        for (genvar i = 0; i < N_CODES; i++) begin : g_cmp
            assign hit[i] = (byte_in == CODE_LIST[i*DATA_W +: DATA_W]);
        end
    endgenerate

    // Collision flag and the stuffed replacement byte.
    always_comb begin
        needs_esc = |hit;
        flipped   = byte_in ^ FLIP_MASK;
    end
endmodule

// File: rtl/fstuff_seq.sv
// Module: fstuff_seq
// Purpose: sequences start marker, payload, escape pairs and end marker into
// a single registered output beat. The input byte is held (ready low) while a
// prefix or marker is emitted, so no payload storage is needed.
// Assumes: the upstream holds valid/data/last stable until accepted.
module fstuff_seq
    import fstuff_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] SOP_CODE = 8'h7E,
    parameter logic [DATA_W-1:0] EOP_CODE = 8'h7F,
    parameter logic [DATA_W-1:0] ESC_CODE = 8'h7D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_raw,
    input  logic [DATA_W-1:0] in_flipped,
    input  logic              in_needs_esc,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);
    fs_phase_e         phase_q, phase_d;
    logic              slot_free;
    logic              load;
    logic [DATA_W-1:0] ld_data;
    logic              ld_last;
    logic              take;

    // Choose the next beat, the next phase and whether the input byte is consumed.
    always_comb begin
        slot_free = !out_valid || out_ready;
        load      = 1'b0;
        ld_data   = in_raw;
        ld_last   = 1'b0;
        take      = 1'b0;
        phase_d   = phase_q;
        unique case (phase_q)
            PH_OPEN: begin
                if (in_valid) begin
                    load    = 1'b1;
                    ld_data = SOP_CODE;
                    phase_d = PH_BODY;
                end
            end
            PH_BODY: begin
                if (in_valid) begin
                    load = 1'b1;
                    if (in_needs_esc) begin
                        ld_data = ESC_CODE;
                        phase_d = PH_TAIL;
                    end else begin
                        ld_data = in_raw;
                        take    = 1'b1;
                        phase_d = in_last ? PH_CLOSE : PH_BODY;
                    end
                end
            end
            PH_TAIL: begin
                if (in_valid) begin
                    load    = 1'b1;
                    ld_data = in_flipped;
                    take    = 1'b1;
                    phase_d = in_last ? PH_CLOSE : PH_BODY;
                end
            end
            PH_CLOSE: begin
                load    = 1'b1;
                ld_data = EOP_CODE;
                ld_last = 1'b1;
                phase_d = PH_OPEN;
            end
            default: phase_d = PH_OPEN;
        endcase
        if (!slot_free) begin
            load    = 1'b0;
            take    = 1'b0;
            phase_d = phase_q;
        end
        in_ready = take;
    end

    // Phase register and output beat register; both advance only when the slot frees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_OPEN;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (slot_free) begin
            phase_q   <= phase_d;
            out_valid <= load;
            if (load) begin
                out_data <= ld_data;
                out_last <= ld_last;
            end
        end
    end

    // Checker-side view: is the visible output byte a reserved code?
    logic out_is_code;
    always_comb begin
        out_is_code = (out_data == SOP_CODE) || (out_data == EOP_CODE) ||
                      (out_data == ESC_CODE);
    end

    // R7: a stalled beat stays put.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R6: an accepted payload byte produces a non-code beat, never a marker or prefix.
    a_r6_accept_loads_payload: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !out_is_code);

    // R5: output last only ever marks the end marker.
    a_r5_last_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> out_data == EOP_CODE);

    // R2: the beat after a transferred end marker, if any, is a start marker.
    a_r2_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid || out_data == SOP_CODE);

    // R8: with the sink ready and input offered, the next cycle has a beat.
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready && in_valid |=> out_valid);
endmodule

// File: rtl/frame_stuffer.sv
// Module: frame_stuffer (top)
// Purpose: AXI4-Stream byte framer with start/end markers and escape stuffing.
// Assumes: byte-wide streams, synchronous active-low reset, upstream obeys the
// stream rule that a presented beat is held until accepted.
module frame_stuffer #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] SOP_CODE  = 8'h7E,
    parameter logic [DATA_W-1:0] EOP_CODE  = 8'h7F,
    parameter logic [DATA_W-1:0] ESC_CODE  = 8'h7D,
    parameter logic [DATA_W-1:0] FLIP_MASK = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_axis_tdata,
    input  logic              s_axis_tvalid,
    input  logic              s_axis_tlast,
    output logic              s_axis_tready,
    output logic [DATA_W-1:0] m_axis_tdata,
    output logic              m_axis_tvalid,
    output logic              m_axis_tlast,
    input  logic              m_axis_tready
);
    logic              needs_esc;
    logic [DATA_W-1:0] flipped;

    // Code collision detection on the presented byte.
    fstuff_classify #(
        .DATA_W(DATA_W), .SOP_CODE(SOP_CODE), .EOP_CODE(EOP_CODE),
        .ESC_CODE(ESC_CODE), .FLIP_MASK(FLIP_MASK)
    ) u_classify (
        .byte_in   (s_axis_tdata),
        .needs_esc (needs_esc),
        .flipped   (flipped)
    );

    // Framing sequencer and output register.
    fstuff_seq #(
        .DATA_W(DATA_W), .SOP_CODE(SOP_CODE), .EOP_CODE(EOP_CODE),
        .ESC_CODE(ESC_CODE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (s_axis_tvalid),
        .in_last      (s_axis_tlast),
        .in_raw       (s_axis_tdata),
        .in_flipped   (flipped),
        .in_needs_esc (needs_esc),
        .in_ready     (s_axis_tready),
        .out_valid    (m_axis_tvalid),
        .out_data     (m_axis_tdata),
        .out_last     (m_axis_tlast),
        .out_ready    (m_axis_tready)
    );
endmodule

// File: tb/frame_stuffer_tb.sv
// Bench for frame_stuffer: directed corner cases plus seeded random packets,
// compared beat by beat against an expected stream built by bench functions.
module frame_stuffer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] s_data;
    logic       s_valid, s_last, s_ready;
    logic [7:0] m_data;
    logic       m_valid, m_last, m_ready;

    always #2 clk = ~clk;  // 250 MHz

    frame_stuffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_axis_tdata(s_data), .s_axis_tvalid(s_valid), .s_axis_tlast(s_last),
        .s_axis_tready(s_ready),
        .m_axis_tdata(m_data), .m_axis_tvalid(m_valid), .m_axis_tlast(m_last),
        .m_axis_tready(m_ready)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit timed_out = 1'b0;

    logic [7:0]  pay_q[$];
    logic        paylast_q[$];
    logic [10:0] exp_q[$];  // {kind[1:0], last, data}; kind 0 raw, 1 sop, 2 esc, 3 eop
    int          pay_total;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_code(input logic [7:0] b);
        return (b == 8'h7E) || (b == 8'h7F) || (b == 8'h7D);
    endfunction

    // Append one packet to the payload queue and its encoding to the expected queue.
    task automatic add_packet(input logic [7:0] bytes[$]);
        exp_q.push_back({2'd1, 1'b0, 8'h7E});
        foreach (bytes[i]) begin
            pay_q.push_back(bytes[i]);
            paylast_q.push_back(i == bytes.size() - 1);
            pay_total++;
            if (is_code(bytes[i])) begin
                exp_q.push_back({2'd2, 1'b0, 8'h7D});
                exp_q.push_back({2'd2, 1'b0, bytes[i] ^ 8'h20});
            end else begin
                exp_q.push_back({2'd0, 1'b0, bytes[i]});
            end
        end
        exp_q.push_back({2'd3, 1'b1, 8'h7F});
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0: return "R4 raw byte";
            2'd1: return "R2 start marker";
            2'd2: return "R3 escape pair";
            default: return "R5 end marker";
        endcase
    endfunction

    // Run queued traffic to completion under given ready/valid densities.
    task automatic run(input string ctx, input int rdy_pct, input int vld_pct, input bit gap_chk);
        bit   hold = 1'b0;
        bit   stalled = 1'b0;
        bit   started = 1'b0;
        logic [7:0] st_data = '0;
        logic st_last = 1'b0;
        int   accepted = 0;
        int   gaps = 0;
        int   expect_acc = pay_q.size();
        while ((pay_q.size() > 0 || exp_q.size() > 0) && !timed_out) begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                timed_out = 1'b1;
                break;
            end
            if (pay_q.size() > 0) begin
                s_valid = hold || (($urandom % 100) < vld_pct);
                s_data  = pay_q[0];
                s_last  = paylast_q[0];
            end else begin
                s_valid = 1'b0;
            end
            m_ready = (($urandom % 100) < rdy_pct);
            #1;
            if (stalled) begin
                chk({"R7 stall hold valid ", ctx}, m_valid, 1'b1);
                chk({"R7 stall hold data ", ctx}, {m_last, m_data}, {st_last, st_data});
            end
            if (m_valid) started = 1'b1;
            if (gap_chk && started && exp_q.size() > 0 && !m_valid) gaps++;
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    chk({"R6 unexpected extra beat ", ctx}, 1, 0);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk({kind_tag(e[10:9]), " data ", ctx}, m_data, e[7:0]);
                    chk({"R5 tlast ", ctx}, m_last, e[8]);
                end
            end
            stalled = m_valid && !m_ready;
            st_data = m_data;
            st_last = m_last;
            if (s_valid && s_ready) begin
                void'(pay_q.pop_front());
                void'(paylast_q.pop_front());
                accepted++;
                hold = 1'b0;
            end else begin
                hold = s_valid;
            end
        end
        chk({"R6 accepted count ", ctx}, accepted, expect_acc);
        if (gap_chk) chk({"R8 idle cycles ", ctx}, gaps, 0);
        @(negedge clk);
        s_valid = 1'b0;
        m_ready = 1'b1;
    endtask

    initial begin
        logic [7:0] pk[$];
        void'($urandom(32'h5EED_0042));
        pay_total = 0;
        rst_n = 1'b0; s_valid = 1'b1; s_data = 8'h11; s_last = 1'b0; m_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset tvalid", m_valid, 1'b0);
        chk("R1 reset tready", s_ready, 1'b0);
        @(negedge clk);
        s_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 idle tvalid", m_valid, 1'b0);
        chk("R1 idle tready", s_ready, 1'b0);

        // R9: single-byte packets, plain and code-valued.
        pk = {8'h41}; add_packet(pk);
        run("R9 single plain", 100, 100, 1'b0);
        pk = {8'h7D}; add_packet(pk);
        run("R9 single escaped", 100, 100, 1'b0);

        // R3: every code, back to back, under backpressure.
        pk = {8'h7E, 8'h7F, 8'h7D, 8'h5E, 8'h7E}; add_packet(pk);
        run("R3 all codes", 50, 100, 1'b0);

        // R8: continuous traffic, sink always ready, several packets.
        for (int p = 0; p < 6; p++) begin
            pk = {};
            for (int i = 0; i <= p; i++) pk.push_back((i % 3 == 0) ? 8'h7F : 8'(p * 16 + i));
            add_packet(pk);
        end
        run("R8 back-to-back", 100, 100, 1'b1);

        // Random traffic with code-biased bytes and random stalls on both sides.
        for (int p = 0; p < 60; p++) begin
            int len;
            pk = {};
            len = 1 + ($urandom % 12);
            for (int i = 0; i < len; i++) begin
                int r;
                r = $urandom % 10;
                pk.push_back(r < 3 ? 8'h7D + 8'(r) : 8'($urandom));
            end
            add_packet(pk);
        end
        run("random", 60, 70, 1'b0);

        if (timed_out) chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule